// File: doc/BRIEF.md
# Maskable Interrupt Vector Fetch

This block takes one level-sensitive maskable interrupt request into a small processor core. The raw request is passed through a clock synchronizer and qualified by an interrupt-enable flag. When the core signals that it sits between two instructions, a pending, enabled request is accepted.

On acceptance the block runs two back-to-back acknowledge bus cycles. Each cycle lasts until the bus reports ready. The type byte on the low data lane is captured at the end of the second cycle and turned into a vector-table address by shifting it left two places. Accepting the interrupt clears the enable flag.

A separate active-low test input, also synchronized, stalls the core while it executes a wait instruction and the input is not yet asserted.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the enable flag is 0, `ack_cyc`, `ack_second` and `vec_valid` are 0, and the synchronized test input reads as deasserted (1), so `stall` equals `wait_req`.
- R2: `irq_req` passes through a two-stage synchronizer. A request driven before clock edge k can be accepted no earlier than edge k+2, and `ack_cyc` goes high after that edge.
- R3: While the enable flag is 0, a request is never accepted, whatever its level and whatever the other inputs are.
- R4: The request is level-sensitive. If the synchronized request is low at every edge where the flag and the boundary input are both high, the request is not accepted.
- R5: A request is accepted only at an edge where `insn_boundary` is 1 and no acknowledge sequence is in progress.
- R6: After acceptance, `ack_cyc` stays high for exactly two acknowledge cycles. `ack_second` is 0 in the first cycle and 1 in the second. Each cycle ends at the first edge at which `bus_rdy` is 1.
- R7: The type byte is taken from `data_lo[7:0]` only at the edge that ends the second acknowledge cycle. Data present during the first cycle is never used.
- R8: In the cycle after that capture, `vec_valid` is 1 for one cycle, and `vec_addr` equals the type times four, zero-extended to 18 bits (type 0xFF gives 0x003FC).
- R9: Acceptance clears the enable flag at the same edge at which `ack_cyc` rises, so a held request is not taken again until the flag is set. `ien_clr` clears the flag and `ien_set` sets it. Acceptance beats both, and `ien_clr` beats `ien_set`.
- R10: `test_n` (active low) passes through a two-stage synchronizer. `stall` is 1 exactly when `wait_req` is 1 and the synchronized `test_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Asynchronous level interrupt request |
| ien_set | input | 1 | Software sets the enable flag |
| ien_clr | input | 1 | Software clears the enable flag |
| insn_boundary | input | 1 | Core is between instructions |
| bus_rdy | input | 1 | Current acknowledge bus cycle completes |
| data_lo | input | 8 | Low data byte carrying the type |
| wait_req | input | 1 | Core is executing a wait instruction |
| test_n | input | 1 | Asynchronous active-low test input |
| ack_cyc | output | 1 | Acknowledge bus cycle in progress |
| ack_second | output | 1 | Current acknowledge cycle is the second |
| vec_valid | output | 1 | One-cycle strobe for `vec_addr` |
| vec_addr | output | 18 | Vector-table address, type times four |
| ien | output | 1 | Interrupt-enable flag |
| stall | output | 1 | Hold the core in its wait instruction |

## Verification
A sequencer stuck in, or skipping, an acknowledge state shows on `ack_cyc` and `ack_second` in the very next cycle. The bench compares those two outputs every cycle against its own model.

A wrong enable flag appears directly on `ien`. It also shows as an acknowledge that starts when it should not, or fails to start, one edge after a boundary.

A capture at the wrong moment or a wrong scaling shows on `vec_addr` in the strobe cycle. A synchronizer of the wrong depth shifts `ack_cyc` or `stall` by one cycle, which the per-cycle comparison catches.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_FIRST = 2'd1,
        ACK_LAST  = 2'd2
    } ack_state_e;

    typedef struct packed {
        ack_state_e st;
        logic       ien;
    } seq_regs_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_vec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_sync,
    input  logic boundary,
    input  logic en_set,
    input  logic en_clr,
    input  logic rdy,
    output logic in_ack,
    output logic in_last,
    output logic capture,
    output logic en_flag
);
    seq_regs_t r_d, r_q;
    logic      accept;

    always_comb begin
        r_d     = r_q;
        accept  = (r_q.st == ACK_IDLE) && req_sync && r_q.ien && boundary;
        capture = (r_q.st == ACK_LAST) && rdy;

        case (r_q.st)
            ACK_IDLE:  if (accept) r_d.st = ACK_FIRST;
            ACK_FIRST: if (rdy)    r_d.st = ACK_LAST;
            ACK_LAST:  if (rdy)    r_d.st = ACK_IDLE;
            default:               r_d.st = ACK_IDLE;
        endcase

        if (accept)      r_d.ien = 1'b0;
        else if (en_clr) r_d.ien = 1'b0;
        else if (en_set) r_d.ien = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ACK_IDLE, ien: 1'b0};
        else        r_q <= r_d;
    end

    assign in_ack  = (r_q.st != ACK_IDLE);
    assign in_last = (r_q.st == ACK_LAST);
    assign en_flag = r_q.ien;
endmodule

// File: rtl/irq_vec_calc.sv
module irq_vec_calc #(
    parameter int TYPE_W = 8,
    parameter int ADDR_W = 18,
    parameter int SHIFT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [TYPE_W-1:0] type_in,
    output logic              vld,
    output logic [ADDR_W-1:0] addr
);
    localparam int WIDE_W = TYPE_W + SHIFT;

    logic              vld_d, vld_q;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [WIDE_W-1:0] scaled;

    always_comb begin
        scaled = {type_in, {SHIFT{1'b0}}};
        vld_d  = capture;
        addr_d = addr_q;
        if (capture) addr_d = ADDR_W'(scaled);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            vld_q  <= vld_d;
            addr_q <= addr_d;
        end
    end

    assign vld  = vld_q;
    assign addr = addr_q;
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
    parameter int TYPE_W      = 8,
    parameter int ADDR_W      = 18,
    parameter int SCALE_SHIFT = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              ien_set,
    input  logic              ien_clr,
    input  logic              insn_boundary,
    input  logic              bus_rdy,
    input  logic [TYPE_W-1:0] data_lo,
    input  logic              wait_req,
    input  logic              test_n,
    output logic              ack_cyc,
    output logic              ack_second,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              ien,
    output logic              stall
);
    logic irq_s, test_n_s, cap;

    irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_irq_sync (
        .clk(clk), .rst_n(rst_n), .din(irq_req), .dout(irq_s)
    );

    irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_test_sync (
        .clk(clk), .rst_n(rst_n), .din(test_n), .dout(test_n_s)
    );

    irq_ack_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req_sync(irq_s), .boundary(insn_boundary),
        .en_set(ien_set), .en_clr(ien_clr), .rdy(bus_rdy),
        .in_ack(ack_cyc), .in_last(ack_second), .capture(cap), .en_flag(ien)
    );

    irq_vec_calc #(.TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .SHIFT(SCALE_SHIFT)) u_calc (
        .clk(clk), .rst_n(rst_n), .capture(cap), .type_in(data_lo),
        .vld(vec_valid), .addr(vec_addr)
    );

    assign stall = wait_req && test_n_s;
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk #(
    parameter int TYPE_W      = 8,
    parameter int ADDR_W      = 18,
    parameter int SCALE_SHIFT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_boundary,
    input logic              bus_rdy,
    input logic [TYPE_W-1:0] data_lo,
    input logic              wait_req,
    input logic              ack_cyc,
    input logic              ack_second,
    input logic              vec_valid,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              ien,
    input logic              stall
);
    p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_cyc && !ien) |=> !ack_cyc);

    p_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_cyc && !insn_boundary) |=> !ack_cyc);

    p_accept_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_cyc) |-> !ien);

    p_capture_point_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack_second && bus_rdy));

    p_addr_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_addr == (ADDR_W'($past(data_lo)) << SCALE_SHIFT)));

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    p_second_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_cyc && !ack_second && bus_rdy) |=> ack_second);

    p_no_stall_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_req |-> !stall);
endmodule

bind irq_vector_unit irq_vector_unit_chk #(
    .TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .SCALE_SHIFT(SCALE_SHIFT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .bus_rdy(bus_rdy),
    .data_lo(data_lo), .wait_req(wait_req), .ack_cyc(ack_cyc),
    .ack_second(ack_second), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .ien(ien), .stall(stall)
);

// File: tb/irq_vector_unit_test.sv
module irq_vector_unit_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_req = 0, ien_set = 0, ien_clr = 0, insn_boundary = 0, bus_rdy = 0;
    logic [7:0] data_lo = 8'h00;
    logic wait_req = 0, test_n = 1;
    logic ack_cyc, ack_second, vec_valid, ien, stall;
    logic [17:0] vec_addr;

    int checks = 0, errors = 0;

    // bench model state
    logic m_s1 = 0, m_s2 = 0, m_t1 = 1, m_t2 = 1, m_ien = 0, m_vv = 0;
    logic [1:0] m_st = 0;
    logic [17:0] m_va = '0;

    always #2.5 clk = ~clk;

    irq_vector_unit uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ien_set(ien_set),
        .ien_clr(ien_clr), .insn_boundary(insn_boundary), .bus_rdy(bus_rdy),
        .data_lo(data_lo), .wait_req(wait_req), .test_n(test_n),
        .ack_cyc(ack_cyc), .ack_second(ack_second), .vec_valid(vec_valid),
        .vec_addr(vec_addr), .ien(ien), .stall(stall)
    );

    function automatic logic [17:0] exp_addr(input logic [7:0] t);
        return {8'h00, t, 2'b00};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic acc, cap;
        logic [1:0] st_n;
        acc = (m_st == 2'd0) && m_s2 && m_ien && insn_boundary;
        cap = (m_st == 2'd2) && bus_rdy;
        st_n = m_st;
        case (m_st)
            2'd0: if (acc) st_n = 2'd1;
            2'd1: if (bus_rdy) st_n = 2'd2;
            default: if (bus_rdy) st_n = 2'd0;
        endcase
        if (acc) m_ien = 0;
        else if (ien_clr) m_ien = 0;
        else if (ien_set) m_ien = 1;
        m_vv = cap;
        if (cap) m_va = exp_addr(data_lo);
        m_st = st_n;
        m_s2 = m_s1; m_s1 = irq_req;
        m_t2 = m_t1; m_t1 = test_n;
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(ack_cyc == (m_st != 0), tag, 32'(ack_cyc), 32'(m_st != 0));
        chk(ack_second == (m_st == 2), "R6", 32'(ack_second), 32'(m_st == 2));
        chk(ien == m_ien, "R9", 32'(ien), 32'(m_ien));
        chk(vec_valid == m_vv, "R8", 32'(vec_valid), 32'(m_vv));
        if (m_vv) chk(vec_addr == m_va, "R7", 32'(vec_addr), 32'(m_va));
        chk(stall == (wait_req && m_t2), "R10", 32'(stall), 32'(wait_req && m_t2));
    endtask

    task automatic idle_inputs();
        ien_set = 0; ien_clr = 0; insn_boundary = 0; bus_rdy = 0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(!ien && !ack_cyc && !ack_second && !vec_valid, "R1",
            {28'd0, ien, ack_cyc, ack_second, vec_valid}, 32'd0);
        wait_req = 1;
        #1;
        chk(stall == 1'b1, "R1", 32'(stall), 32'd1);
        wait_req = 0;

        // R3: flag clear, held request at boundary is never taken
        irq_req = 1; insn_boundary = 1; bus_rdy = 1;
        repeat (6) step("R3");
        chk(!ack_cyc, "R3", 32'(ack_cyc), 32'd0);

        // R9: clear beats set
        irq_req = 0; insn_boundary = 0; ien_set = 1; ien_clr = 1;
        step("R9");
        chk(ien == 0, "R9", 32'(ien), 32'd0);
        ien_clr = 0;
        step("R9");
        chk(ien == 1, "R9", 32'(ien), 32'd1);
        ien_set = 0;
        repeat (3) step("R2");

        // R2: two-stage synchronizer latency
        irq_req = 1; insn_boundary = 1; bus_rdy = 0;
        step("R2");
        step("R2");
        chk(!ack_cyc, "R2", 32'(ack_cyc), 32'd0);
        step("R2");
        chk(ack_cyc && !ack_second && !ien, "R2",
            {29'd0, ack_cyc, ack_second, ien}, 32'd4);

        // R6/R7: wait states, data in first cycle ignored
        data_lo = 8'h11;
        repeat (2) step("R6");
        chk(ack_cyc && !ack_second, "R6", 32'(ack_second), 32'd0);
        bus_rdy = 1; step("R6");
        chk(ack_second, "R6", 32'(ack_second), 32'd1);
        bus_rdy = 0; data_lo = 8'h22; step("R6");
        bus_rdy = 1; data_lo = 8'hFF; step("R7");
        chk(vec_valid && vec_addr == 18'h003FC, "R8", 32'(vec_addr), 32'h3FC);
        bus_rdy = 0;
        // R9: held level not taken again while flag clear
        repeat (4) step("R9");
        chk(!ack_cyc, "R9", 32'(ack_cyc), 32'd0);

        // R4: short pulse absent at any boundary is dropped
        irq_req = 0; insn_boundary = 0; ien_set = 1; step("R4");
        ien_set = 0; repeat (3) step("R4");
        irq_req = 1; step("R4");
        irq_req = 0; repeat (2) step("R4");
        insn_boundary = 1; repeat (4) step("R4");
        chk(!ack_cyc, "R4", 32'(ack_cyc), 32'd0);

        // R5: pending request waits for boundary
        insn_boundary = 0; irq_req = 1; repeat (5) step("R5");
        chk(!ack_cyc, "R5", 32'(ack_cyc), 32'd0);
        insn_boundary = 1; step("R5");
        chk(ack_cyc, "R5", 32'(ack_cyc), 32'd1);
        insn_boundary = 0; bus_rdy = 1; data_lo = 8'h00; repeat (2) step("R8");
        chk(vec_valid && vec_addr == 18'h0, "R8", 32'(vec_addr), 32'h0);
        bus_rdy = 0; irq_req = 0;

        // R10: test input through synchronizer
        wait_req = 1; test_n = 0; step("R10");
        chk(stall, "R10", 32'(stall), 32'd1);
        step("R10");
        chk(!stall, "R10", 32'(stall), 32'd0);
        test_n = 1; wait_req = 0;

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 7) == 0) irq_req = ~irq_req;
            ien_set = ($urandom_range(0, 9) == 0);
            ien_clr = ($urandom_range(0, 19) == 0);
            insn_boundary = $urandom_range(0, 1);
            bus_rdy = ($urandom_range(0, 2) != 0);
            data_lo = 8'($urandom);
            wait_req = $urandom_range(0, 1);
            if ($urandom_range(0, 5) == 0) test_n = ~test_n;
            step("R5");
        end
        idle_inputs();

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule